// File: doc/BRIEF.md
# Three-Level Interrupt Priority Encoder with Acknowledge Steering

This block sits between three peripheral interrupt sources and a processor that has only two interrupt-priority pins. One pin serves as both the top and bottom priority bits. Because of that shared pin, the processor can see only levels 0, 2, 5 and 7. The three sources each get one of those levels. The serial controller is at level 7, and it supplies its own vector. The expansion slot is at level 5, and its acknowledge is handed to whatever device is fitted there. The parallel port is at level 2, and it is served by an autovector. The block synchronizes the three active-low requests and picks the highest one. It then drives the two priority pins from a register, so the level the processor sees never passes through an intermediate value.

During an interrupt-acknowledge bus cycle, the block steers the response. It recognises that cycle from the address strobe and function code 111, and it reads the acknowledged level from the three low address lines. For level 7 it pulls the serial controller's acknowledge. For level 5 it pulls the expansion acknowledge. For every other level it asserts the valid-peripheral-address line, so the processor takes an autovector. This covers the parallel port at level 2 and any spurious level, so a stray acknowledge never stalls the bus. All acknowledge-side outputs are registered and release on the clock edge after the strobe goes high.

Top module: `irq_level_encoder`

## Requirements
- R1: While `rst` is high at a clock edge, every output is driven high (inactive) after that edge.
- R2: A serial request (`ser_req_n` low) drives both `ipl02_n` and `ipl1_n` low (level 7), SYNC_STAGES+1 clock edges after it is sampled.
- R3: An expansion request alone drives `ipl02_n` low and `ipl1_n` high (level 5), with the same latency.
- R4: A parallel-port request alone drives `ipl02_n` high and `ipl1_n` low (level 2), with the same latency.
- R5: With several requests pending, the pins show the highest level among them: 7 over 5 over 2.
- R6: With no request pending, both priority pins are high (level 0), with the same latency after the last request is removed.
- R7: An acknowledge cycle is `as_n` low with `fc` equal to 3'b111. The acknowledge-side outputs follow the inputs sampled at the previous clock edge.
- R8: Acknowledging level 7 (`ack_lvl` = 3'b111) drives only `ser_ack_n` low.
- R9: Acknowledging level 5 (`ack_lvl` = 3'b101) drives only `exp_ack_n` low.
- R10: Acknowledging level 2 (`ack_lvl` = 3'b010) drives only `vpa_n` low. No acknowledge goes to the parallel port.
- R11: Acknowledging any other level (0, 1, 3, 4 or 6) drives only `vpa_n` low.
- R12: After a clock edge that samples `as_n` high, `vpa_n`, `ser_ack_n` and `exp_ack_n` are all high.
- R13: With `as_n` low and `fc` not equal to 3'b111, no acknowledge-side output is asserted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous reset, active high |
| ser_req_n | input | 1 | Serial controller interrupt request, active low |
| exp_req_n | input | 1 | Expansion slot interrupt request, active low |
| par_req_n | input | 1 | Parallel port interrupt request, active low |
| as_n | input | 1 | Processor address strobe, active low |
| fc | input | 3 | Processor function code |
| ack_lvl | input | 3 | Acknowledged level from the low address lines |
| ipl02_n | output | 1 | Shared top/bottom priority pin, active low |
| ipl1_n | output | 1 | Middle priority pin, active low |
| vpa_n | output | 1 | Valid peripheral address (autovector request), active low |
| ser_ack_n | output | 1 | Interrupt acknowledge to the serial controller, active low |
| exp_ack_n | output | 1 | Interrupt acknowledge to the expansion slot, active low |

## Verification
The requests are applied one at a time first, which separates the three pin encodings from each other and from the idle state. They are then applied all together and withdrawn from the top down, which shows whether priority is resolved or whether the pins merely follow the last change. Acknowledge cycles are run at each of the eight levels. These show that only levels 7 and 5 are routed to a device and that every other level gets an autovector. A strobe held low with a non-acknowledge function code, and a function code of 111 with the strobe high, show that both conditions are required. A behavioural model, compared on every clock, checks the synchronizer latency and the one-clock release.

// File: rtl/irq_enc_pkg.sv
package irq_enc_pkg;

    typedef enum logic [2:0] {
        LVL_NONE = 3'd0,
        LVL_PAR  = 3'd2,
        LVL_EXP  = 3'd5,
        LVL_SER  = 3'd7
    } irq_lvl_e;

    typedef struct packed {
        logic ipl02_n;
        logic ipl1_n;
    } ipl_pins_t;

    typedef struct packed {
        logic vpa_n;
        logic ser_ack_n;
        logic exp_ack_n;
    } ack_pins_t;

    localparam logic [2:0] FC_IACK   = 3'b111;
    localparam ipl_pins_t  IPL_IDLE  = '{ipl02_n: 1'b1, ipl1_n: 1'b1};
    localparam ack_pins_t  ACK_IDLE  = '{vpa_n: 1'b1, ser_ack_n: 1'b1, exp_ack_n: 1'b1};

    function automatic irq_lvl_e pick_level(input logic ser, input logic exp, input logic par);
        if (ser)      return LVL_SER;
        else if (exp) return LVL_EXP;
        else if (par) return LVL_PAR;
        else          return LVL_NONE;
    endfunction

    function automatic ipl_pins_t level_pins(input irq_lvl_e lvl);
        ipl_pins_t p;
        p = IPL_IDLE;
        case (lvl)
            LVL_SER: begin p.ipl02_n = 1'b0; p.ipl1_n = 1'b0; end
            LVL_EXP: p.ipl02_n = 1'b0;
            LVL_PAR: p.ipl1_n  = 1'b0;
            default: p = IPL_IDLE;
        endcase
        return p;
    endfunction

    function automatic ack_pins_t ack_route(input logic [2:0] lvl);
        ack_pins_t a;
        a = ACK_IDLE;
        if (lvl == LVL_SER)      a.ser_ack_n = 1'b0;
        else if (lvl == LVL_EXP) a.exp_ack_n = 1'b0;
        else                     a.vpa_n     = 1'b0;
        return a;
    endfunction

endpackage

// File: rtl/req_sync.sv
module req_sync #(
    parameter int WIDTH  = 3,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] req_n,
    output logic [WIDTH-1:0] req
);
    localparam int LAST = STAGES - 1;

    logic [STAGES-1:0][WIDTH-1:0] chain;

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) chain[s] <= '0;
                else     chain[s] <= ~req_n;
            end
        end else begin : g_rest
            always_ff @(posedge clk) begin
                if (rst) chain[s] <= '0;
                else     chain[s] <= chain[s-1];
            end
        end
    end

    assign req = chain[LAST];

endmodule

// File: rtl/irq_prio_encoder.sv
module irq_prio_encoder
    import irq_enc_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic ser,
    input  logic exp,
    input  logic par,
    output logic ipl02_n,
    output logic ipl1_n
);
    ipl_pins_t pins_q;
    irq_lvl_e  lvl;

    always_comb lvl = pick_level(ser, exp, par);

    always_ff @(posedge clk) begin
        if (rst) pins_q <= IPL_IDLE;
        else     pins_q <= level_pins(lvl);
    end

    assign ipl02_n = pins_q.ipl02_n;
    assign ipl1_n  = pins_q.ipl1_n;

    // R2
    ser_wins_chk: assert property (@(posedge clk) disable iff (rst)
        ser |=> (!ipl02_n && !ipl1_n));

    // R5
    exp_over_par_chk: assert property (@(posedge clk) disable iff (rst)
        (exp && !ser) |=> (!ipl02_n && ipl1_n));

    // R4
    par_only_chk: assert property (@(posedge clk) disable iff (rst)
        (par && !exp && !ser) |=> (ipl02_n && !ipl1_n));

    // R6
    idle_pins_chk: assert property (@(posedge clk) disable iff (rst)
        (!ser && !exp && !par) |=> (ipl02_n && ipl1_n));

endmodule

// File: rtl/iack_decoder.sv
module iack_decoder
    import irq_enc_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       as_n,
    input  logic [2:0] fc,
    input  logic [2:0] ack_lvl,
    output logic       vpa_n,
    output logic       ser_ack_n,
    output logic       exp_ack_n
);
    ack_pins_t ack_q;
    logic      in_iack;

    always_comb in_iack = !as_n && (fc == FC_IACK);

    always_ff @(posedge clk) begin
        if (rst || !in_iack) ack_q <= ACK_IDLE;
        else                 ack_q <= ack_route(ack_lvl);
    end

    assign vpa_n     = ack_q.vpa_n;
    assign ser_ack_n = ack_q.ser_ack_n;
    assign exp_ack_n = ack_q.exp_ack_n;

    // R12
    strobe_release_chk: assert property (@(posedge clk) disable iff (rst)
        as_n |=> (vpa_n && ser_ack_n && exp_ack_n));

    // R13
    wrong_fc_chk: assert property (@(posedge clk) disable iff (rst)
        (fc != 3'b111) |=> (vpa_n && ser_ack_n && exp_ack_n));

    // R8
    ser_ack_chk: assert property (@(posedge clk) disable iff (rst)
        (!as_n && fc == 3'b111 && ack_lvl == 3'd7) |=> (!ser_ack_n && vpa_n && exp_ack_n));

    // R9
    exp_ack_chk: assert property (@(posedge clk) disable iff (rst)
        (!as_n && fc == 3'b111 && ack_lvl == 3'd5) |=> (!exp_ack_n && vpa_n && ser_ack_n));

    // R11
    autovec_chk: assert property (@(posedge clk) disable iff (rst)
        (!as_n && fc == 3'b111 && ack_lvl != 3'd7 && ack_lvl != 3'd5) |=> (!vpa_n && ser_ack_n && exp_ack_n));

    // R10
    one_ack_chk: assert property (@(posedge clk) disable iff (rst)
        $countones({~vpa_n, ~ser_ack_n, ~exp_ack_n}) <= 1);

endmodule

// File: rtl/irq_level_encoder.sv
module irq_level_encoder #(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       ser_req_n,
    input  logic       exp_req_n,
    input  logic       par_req_n,
    input  logic       as_n,
    input  logic [2:0] fc,
    input  logic [2:0] ack_lvl,
    output logic       ipl02_n,
    output logic       ipl1_n,
    output logic       vpa_n,
    output logic       ser_ack_n,
    output logic       exp_ack_n
);
    localparam int NUM_SRC = 3;

    logic [NUM_SRC-1:0] req;

    req_sync #(.WIDTH(NUM_SRC), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst   (rst),
        .req_n ({ser_req_n, exp_req_n, par_req_n}),
        .req   (req)
    );

    irq_prio_encoder u_prio (
        .clk     (clk),
        .rst     (rst),
        .ser     (req[2]),
        .exp     (req[1]),
        .par     (req[0]),
        .ipl02_n (ipl02_n),
        .ipl1_n  (ipl1_n)
    );

    iack_decoder u_iack (
        .clk       (clk),
        .rst       (rst),
        .as_n      (as_n),
        .fc        (fc),
        .ack_lvl   (ack_lvl),
        .vpa_n     (vpa_n),
        .ser_ack_n (ser_ack_n),
        .exp_ack_n (exp_ack_n)
    );

    // R1
    reset_idle_chk: assert property (@(posedge clk)
        rst |=> (ipl02_n && ipl1_n && vpa_n && ser_ack_n && exp_ack_n));

endmodule

// File: tb/irq_level_encoder_test.sv
module irq_level_encoder_test;
    localparam int SYNC  = 2;
    localparam int DEPTH = SYNC + 1;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ser_req_n = 1'b1, exp_req_n = 1'b1, par_req_n = 1'b1;
    logic       as_n = 1'b1;
    logic [2:0] fc = 3'b000;
    logic [2:0] ack_lvl = 3'd0;
    logic       ipl02_n, ipl1_n, vpa_n, ser_ack_n, exp_ack_n;

    int checks = 0;
    int fails  = 0;
    int lvl_pipe [DEPTH];
    int ack_state = -1;

    always #2 clk = ~clk;

    irq_level_encoder #(.SYNC_STAGES(SYNC)) uut (
        .clk(clk), .rst(rst),
        .ser_req_n(ser_req_n), .exp_req_n(exp_req_n), .par_req_n(par_req_n),
        .as_n(as_n), .fc(fc), .ack_lvl(ack_lvl),
        .ipl02_n(ipl02_n), .ipl1_n(ipl1_n),
        .vpa_n(vpa_n), .ser_ack_n(ser_ack_n), .exp_ack_n(exp_ack_n)
    );

    // Behavioural reference: a delay line of levels and the last acknowledged level
    always @(posedge clk) begin
        int nl;
        nl = !ser_req_n ? 7 : (!exp_req_n ? 5 : (!par_req_n ? 2 : 0));
        for (int i = DEPTH - 1; i > 0; i--) lvl_pipe[i] <= rst ? 0 : lvl_pipe[i-1];
        lvl_pipe[0] <= rst ? 0 : nl;
        if (rst || as_n || fc != 3'b111) ack_state <= -1;
        else                             ack_state <= int'(ack_lvl);
    end

    initial for (int i = 0; i < DEPTH; i++) lvl_pipe[i] = 0;

    function automatic logic [4:0] expected();
        logic [1:0] p;
        logic [2:0] a;
        case (lvl_pipe[DEPTH-1])
            7:       p = 2'b00;
            5:       p = 2'b01;
            2:       p = 2'b10;
            default: p = 2'b11;
        endcase
        if (ack_state < 0)       a = 3'b111;
        else if (ack_state == 7) a = 3'b101;
        else if (ack_state == 5) a = 3'b110;
        else                     a = 3'b011;
        return {p, a};
    endfunction

    task automatic step(input string tag, input int n);
        for (int k = 0; k < n; k++) begin
            logic [4:0] act, exp_v;
            @(negedge clk);
            act   = {ipl02_n, ipl1_n, vpa_n, ser_ack_n, exp_ack_n};
            exp_v = expected();
            checks++;
            if (act !== exp_v) begin
                fails++;
                $display("FAIL %s: {ipl02_n,ipl1_n,vpa_n,ser_ack_n,exp_ack_n} actual %b expected %b at %0t",
                         tag, act, exp_v, $time);
            end
        end
    endtask

    task automatic iack(input string tag, input logic [2:0] f, input logic [2:0] lvl);
        fc = f; ack_lvl = lvl; as_n = 1'b0;
        step(tag, 3);
        as_n = 1'b1;
        step("R12", 2);
    endtask

    initial begin
        repeat (2000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks + 0);
        $finish;
    end

    initial begin
        // R1: reset state
        ser_req_n = 1'b0; as_n = 1'b0; fc = 3'b111; ack_lvl = 3'd7;
        step("R1", 3);
        ser_req_n = 1'b1; as_n = 1'b1; fc = 3'b000;
        rst = 1'b0;
        step("R6", 5);
        // R4: parallel port alone
        par_req_n = 1'b0; step("R4", 5);
        par_req_n = 1'b1; step("R6", 5);
        // R3: expansion alone
        exp_req_n = 1'b0; step("R3", 5);
        exp_req_n = 1'b1; step("R6", 5);
        // R2: serial alone
        ser_req_n = 1'b0; step("R2", 5);
        ser_req_n = 1'b1; step("R6", 5);
        // R5: all pending, withdraw from the top down
        ser_req_n = 1'b0; exp_req_n = 1'b0; par_req_n = 1'b0; step("R5", 5);
        ser_req_n = 1'b1; step("R5", 5);
        exp_req_n = 1'b1; step("R5", 5);
        par_req_n = 1'b1; step("R6", 5);
        exp_req_n = 1'b0; par_req_n = 1'b0; step("R5", 5);
        exp_req_n = 1'b1; par_req_n = 1'b1; step("R6", 5);
        // R13: strobe low but not an acknowledge function code
        iack("R13", 3'b110, 3'd7);
        iack("R13", 3'b101, 3'd5);
        // R7: function code 111 with strobe high gives nothing
        fc = 3'b111; ack_lvl = 3'd7; as_n = 1'b1; step("R7", 3);
        // R8, R9, R10, R11: acknowledge at each level
        iack("R8",  3'b111, 3'd7);
        iack("R9",  3'b111, 3'd5);
        iack("R10", 3'b111, 3'd2);
        for (int l = 0; l < 8; l++) begin
            if (l != 2 && l != 5 && l != 7) iack("R11", 3'b111, 3'(l));
        end
        // R7: acknowledge during pending requests, level changes mid-strobe
        par_req_n = 1'b0; ser_req_n = 1'b0;
        fc = 3'b111; ack_lvl = 3'd7; as_n = 1'b0; step("R7", 2);
        ack_lvl = 3'd2; step("R7", 2);
        as_n = 1'b1; step("R12", 2);
        ser_req_n = 1'b1; par_req_n = 1'b1; step("R6", 5);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule